// File: doc/BRIEF.md
# Pulse Request/Grant Bus Arbiter

This block lets external bus masters borrow a processor's local bus over single-wire request/grant channels. On each channel the master and the processor talk in one-clock low pulses. The master pulses once to ask for the bus. The processor pulses once to hand it over. The master pulses once more to give it back. Each open-drain line is modelled as a separate sensed input and a separate driven output.

The arbiter watches the processor's bus-cycle state to decide when the bus may be released. The inputs it uses are the current T-state, a lock flag, a flag marking the first half of a split (odd-aligned) word access, and a flag marking the first interrupt-acknowledge cycle. While a master owns the bus, the arbiter floats the processor's bus drivers and stops the cycle sequencer from starting a new cycle. After every handback it leaves one dead clock. Lower-numbered channels win when more than one channel is eligible in the same clock.

Top module: `rqgt_arbiter`

## Requirements
- R1: While reset is held, and in the first clock after it is removed with all lines high and T-state idle, every `rq_n_out` bit is 1, `bus_float` is 0, `start_inhibit` is 0 and `hold_owner` is 0.
- R2: A request is recognised on a high-to-low change of `rq_n_in[i]` between two clock samples. A line that stays low over several clocks counts as one pulse only, and it cannot also act as the release.
- R3: If a request was seen in clock k, the arbiter is ready, and `bus_tstate` is idle (code 0) in clock k+1, then `rq_n_out` of that channel is low for exactly clock k+1.
- R4: A grant pulse appears only in a clock where `bus_tstate` is T4 (code 5) or idle (code 0). At most one `rq_n_out` bit is low at any time.
- R5: During active bus cycles (codes T1=1, T2=2, T3=3, wait=4, T4=5), a request is granted at T4 only if it was pending at T1 or T2 of that same cycle. A request first seen in T3, a wait state or T4 is held until T4 of a later cycle.
- R6: A grant at T4 is withheld while `cyc_locked`, `cyc_split_lo` or `cyc_inta_first` is high in that T4 clock. The request stays pending and is granted at the first later T4 that meets all the rules.
- R7: From the clock after the grant until the release, `bus_float` is 1 and `hold_owner` is the one-hot code of the owning channel. `start_inhibit` is 1 in the grant clock and throughout the hold.
- R8: A release pulse on the owner's line ends the hold. In the next clock `bus_float` and `start_inhibit` are 0, and that clock is dead: no grant is issued in it, even with requests pending.
- R9: When channels 0 and 1 are both eligible in the same clock, channel 0 is granted. Channel 1 stays pending and is granted after channel 0's exchange and dead clock.
- R10: A request pulse on a channel that does not own the bus, arriving during a hold, is latched. It is granted in the first ready clock after the dead clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rq_n_in | input | NCH | Sensed level of each request/grant line (low = pulse from master) |
| rq_n_out | output | NCH | Low drives a grant pulse onto each line |
| bus_tstate | input | 3 | Current bus state: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| cyc_locked | input | 1 | A locked instruction is executing |
| cyc_split_lo | input | 1 | Current cycle is the first access of an odd-aligned word |
| cyc_inta_first | input | 1 | Current cycle is the first interrupt acknowledge |
| bus_float | output | 1 | Processor bus drivers must float (hold in progress) |
| start_inhibit | output | 1 | Cycle sequencer must not start a new cycle |
| hold_owner | output | NCH | One-hot owner of the bus during hold, zero otherwise |

## Verification
The assertions assume the cycle sequencer honours `start_inhibit` and `bus_float`, so `bus_tstate` stays idle throughout a hold and in the clock after a grant. They also assume the tstate codes follow a legal T1..T4 order, and that the lock, split and acknowledge flags matter only in T4 clocks. The stimulus keeps to this. Each directed scenario drives idle as soon as a grant is seen. The three qualifier flags are raised only in T4 clocks, and each master pulses its line only to request or to release.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

   localparam int unsigned TS_BITS = 3;

   typedef enum logic [TS_BITS-1:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_WAIT = 3'd4,
      TS_T4   = 3'd5
   } tstate_e;

   typedef enum logic [1:0] {
      ARB_READY = 2'd0,
      ARB_HOLD  = 2'd1,
      ARB_DEAD  = 2'd2
   } arb_e;

endpackage

// File: rtl/rqgt_edge.sv
module rqgt_edge #(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] line_n,
   output logic [NCH-1:0] fall
);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= line_n[i];
         end
         // a pulse counts once: only the high-to-low step is reported
         assign fall[i] = prev_q & ~line_n[i];
      end
   endgenerate

endmodule

// File: rtl/rqgt_track.sv
module rqgt_track #(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] fall,
   input  logic [NCH-1:0] ignore,
   input  logic [NCH-1:0] clear,
   input  logic           ts_early,
   input  logic           ts_end,
   output logic [NCH-1:0] pend,
   output logic [NCH-1:0] elig
);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic pend_q, early_q, seen;

         assign seen = pend_q | (fall[i] & ~ignore[i]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q  <= 1'b0;
               early_q <= 1'b0;
            end else begin
               pend_q <= seen & ~clear[i];
               if (clear[i])              early_q <= 1'b0;
               else if (ts_early && seen) early_q <= 1'b1;
               else if (ts_end)           early_q <= 1'b0;
            end
         end

         assign pend[i] = pend_q;
         assign elig[i] = pend_q & early_q;
      end
   endgenerate

endmodule

// File: rtl/rqgt_pick.sv
module rqgt_pick #(
   parameter int unsigned NCH       = 2,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] win
);

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            win = '0;
            for (int i = NCH - 1; i >= 0; i--) begin
               if (req[i]) begin
                  win    = '0;
                  win[i] = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            win = '0;
            for (int i = 0; i < NCH; i++) begin
               if (req[i]) begin
                  win    = '0;
                  win[i] = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
   import rqgt_pkg::*;
#(
   parameter int unsigned NCH       = 2,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] rq_n_in,
   output logic [NCH-1:0] rq_n_out,
   input  logic [2:0]     bus_tstate,
   input  logic           cyc_locked,
   input  logic           cyc_split_lo,
   input  logic           cyc_inta_first,
   output logic           bus_float,
   output logic           start_inhibit,
   output logic [NCH-1:0] hold_owner
);

   localparam int unsigned MAX_CH = 16;

   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("rqgt_arbiter: NCH must lie in 1..%0d", MAX_CH);
      end
   endgenerate

   tstate_e        ts;
   arb_e           st_q;
   logic [NCH-1:0] owner_q;
   logic [NCH-1:0] fall, ignore, pend, elig, cand, gnt;
   logic           ts_early, ts_end, gate_ok, grant_any, rel_seen;

   assign ts       = tstate_e'(bus_tstate);
   assign ts_early = (ts == TS_T1) || (ts == TS_T2);
   assign ts_end   = (ts == TS_T4);
   assign gate_ok  = !cyc_locked && !cyc_split_lo && !cyc_inta_first;

   rqgt_edge #(.NCH(NCH)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .line_n(rq_n_in),
      .fall  (fall)
   );

   // the owner's pulse during a hold is a release, not a new request
   assign ignore = (st_q == ARB_HOLD) ? owner_q : '0;

   rqgt_track #(.NCH(NCH)) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .fall    (fall),
      .ignore  (ignore),
      .clear   (gnt),
      .ts_early(ts_early),
      .ts_end  (ts_end),
      .pend    (pend),
      .elig    (elig)
   );

   always_comb begin
      cand = '0;
      if (st_q == ARB_READY) begin
         if (ts == TS_IDLE)          cand = pend;
         else if (ts_end && gate_ok) cand = elig;
      end
   end

   rqgt_pick #(.NCH(NCH), .LOW_FIRST(LOW_FIRST)) i_pick (
      .req(cand),
      .win(gnt)
   );

   assign grant_any = |gnt;
   assign rel_seen  = |(fall & owner_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ARB_READY;
         owner_q <= '0;
      end else begin
         unique case (st_q)
            ARB_READY: if (grant_any) begin
               st_q    <= ARB_HOLD;
               owner_q <= gnt;
            end
            ARB_HOLD: if (rel_seen) begin
               st_q    <= ARB_DEAD;
               owner_q <= '0;
            end
            default: st_q <= ARB_READY;
         endcase
      end
   end

   assign rq_n_out      = ~gnt;
   assign bus_float     = (st_q == ARB_HOLD);
   assign hold_owner    = bus_float ? owner_q : '0;
   assign start_inhibit = grant_any | bus_float;

   // R4
   grant_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&rq_n_out) |-> (ts == TS_T4 || ts == TS_IDLE));

   // R4
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~rq_n_out));

   // R6
   t4_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&rq_n_out) && ts == TS_T4) |-> gate_ok);

   // R7
   float_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&rq_n_out) |=> (bus_float && hold_owner == ~$past(rq_n_out)));

   // R7
   owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_float |-> $onehot(hold_owner));

   // R8
   release_ends_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_float && |(fall & hold_owner)) |=> (!bus_float && !start_inhibit));

   // R8
   dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_float) |-> (&rq_n_out));

endmodule

// File: tb/test_rqgt_arbiter.sv
module test_rqgt_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] TI = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, T4 = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rq_n_in = 2'b11;
   logic [1:0] rq_n_out;
   logic [2:0] bus_tstate = TI;
   logic       cyc_locked = 1'b0, cyc_split_lo = 1'b0, cyc_inta_first = 1'b0;
   logic       bus_float, start_inhibit;
   logic [1:0] hold_owner;

   int vectors = 0;
   int miss = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rqgt_arbiter #(.NCH(2), .LOW_FIRST(1'b1)) i_rqgt_arbiter (
      .clk           (clk),
      .rst_n         (rst_n),
      .rq_n_in       (rq_n_in),
      .rq_n_out      (rq_n_out),
      .bus_tstate    (bus_tstate),
      .cyc_locked    (cyc_locked),
      .cyc_split_lo  (cyc_split_lo),
      .cyc_inta_first(cyc_inta_first),
      .bus_float     (bus_float),
      .start_inhibit (start_inhibit),
      .hold_owner    (hold_owner)
   );

   // one clock: drive just after the rising edge, leave for sampling at the falling edge
   task automatic cyc(input logic [2:0] t, input logic [1:0] r,
                      input logic lk = 1'b0, input logic sp = 1'b0, input logic ia = 1'b0);
      @(posedge clk);
      #1;
      bus_tstate     = t;
      rq_n_in        = r;
      cyc_locked     = lk;
      cyc_split_lo   = sp;
      cyc_inta_first = ia;
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [1:0] e_rq, input logic e_fl,
                      input logic e_inh, input logic [1:0] e_own);
      vectors++;
      if ({rq_n_out, bus_float, start_inhibit, hold_owner} !== {e_rq, e_fl, e_inh, e_own}) begin
         miss++;
         $display("FAIL %s: rq_n_out=%b float=%b inhibit=%b owner=%b, expected %b %b %b %b",
                  req, rq_n_out, bus_float, start_inhibit, hold_owner, e_rq, e_fl, e_inh, e_own);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 in reset", 2'b11, 0, 0, 2'b00);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 2'b11, 0, 0, 2'b00);
   endtask

   task automatic t_idle_grant();
      cyc(TI, 2'b10);  chk("R3 no grant in request clock", 2'b11, 0, 0, 2'b00);
      cyc(TI, 2'b11);  chk("R3 idle grant next clock", 2'b10, 0, 1, 2'b00);
      cyc(TI, 2'b11);  chk("R7 hold begins", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b11);  chk("R7 hold kept", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b10);  chk("R8 float during release clock", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b11);  chk("R8 reclaim after release", 2'b11, 0, 0, 2'b00);
      cyc(TI, 2'b11);  chk("R8 ready again", 2'b11, 0, 0, 2'b00);
   endtask

   task automatic t_held_low();
      cyc(TI, 2'b10);
      cyc(TI, 2'b10);  chk("R2 held-low line granted once", 2'b10, 0, 1, 2'b00);
      cyc(TI, 2'b10);  chk("R2 held low is not a release", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b11);  chk("R2 still held", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b10);
      cyc(TI, 2'b11);  chk("R2 release edge honoured", 2'b11, 0, 0, 2'b00);
      cyc(TI, 2'b11);  chk("R2 no second grant", 2'b11, 0, 0, 2'b00);
   endtask

   task automatic release0();
      cyc(TI, 2'b11);  chk("R7 hold after T4 grant", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b10);
      cyc(TI, 2'b11);  chk("R8 dead clock", 2'b11, 0, 0, 2'b00);
   endtask

   task automatic t_late_request();
      cyc(T1, 2'b11);
      cyc(T2, 2'b11);
      cyc(T3, 2'b10);
      cyc(T4, 2'b11);  chk("R5 request in T3 not granted at T4", 2'b11, 0, 0, 2'b00);
      cyc(T1, 2'b11);
      cyc(T2, 2'b11);
      cyc(T3, 2'b11);  chk("R4 no grant in T3", 2'b11, 0, 0, 2'b00);
      cyc(T4, 2'b11);  chk("R5 late request granted next T4", 2'b10, 0, 1, 2'b00);
      release0();
      cyc(T1, 2'b11);
      cyc(T2, 2'b10);
      cyc(T3, 2'b11);
      cyc(T4, 2'b11);  chk("R5 request in T2 granted same T4", 2'b10, 0, 1, 2'b00);
      release0();
   endtask

   task automatic t_gates();
      cyc(T1, 2'b10);  cyc(T2, 2'b11);  cyc(T3, 2'b11);
      cyc(T4, 2'b11, 1, 0, 0);  chk("R6 locked blocks grant", 2'b11, 0, 0, 2'b00);
      cyc(T1, 2'b11);  cyc(T2, 2'b11);  cyc(T3, 2'b11);
      cyc(T4, 2'b11, 0, 1, 0);  chk("R6 split word blocks grant", 2'b11, 0, 0, 2'b00);
      cyc(T1, 2'b11);  cyc(T2, 2'b11);  cyc(T3, 2'b11);
      cyc(T4, 2'b11, 0, 0, 1);  chk("R6 first acknowledge blocks grant", 2'b11, 0, 0, 2'b00);
      cyc(T1, 2'b11);  cyc(T2, 2'b11);  cyc(T3, 2'b11);
      cyc(T4, 2'b11);  chk("R6 pending request granted when clear", 2'b10, 0, 1, 2'b00);
      release0();
   endtask

   task automatic t_priority();
      cyc(TI, 2'b00);
      cyc(TI, 2'b11);  chk("R9 channel 0 wins", 2'b10, 0, 1, 2'b00);
      cyc(TI, 2'b11);  chk("R9 channel 0 owns", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b10);
      cyc(TI, 2'b11);  chk("R8 dead clock blocks pending channel 1", 2'b11, 0, 0, 2'b00);
      cyc(TI, 2'b11);  chk("R9 channel 1 granted after", 2'b01, 0, 1, 2'b00);
      cyc(TI, 2'b11);  chk("R9 channel 1 owns", 2'b11, 1, 1, 2'b10);
   endtask

   task automatic t_hold_request();
      cyc(TI, 2'b10);  chk("R10 other-channel pulse in hold", 2'b11, 1, 1, 2'b10);
      cyc(TI, 2'b11);  chk("R10 hold unaffected", 2'b11, 1, 1, 2'b10);
      cyc(TI, 2'b01);
      cyc(TI, 2'b11);  chk("R10 dead clock", 2'b11, 0, 0, 2'b00);
      cyc(TI, 2'b11);  chk("R10 latched request granted", 2'b10, 0, 1, 2'b00);
      cyc(TI, 2'b11);  chk("R10 channel 0 owns", 2'b11, 1, 1, 2'b01);
      cyc(TI, 2'b10);
      cyc(TI, 2'b11);
      cyc(TI, 2'b11);  chk("R10 nothing left pending", 2'b11, 0, 0, 2'b00);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      miss++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end

   initial begin
      t_reset();
      t_idle_grant();
      t_held_low();
      t_late_request();
      t_gates();
      t_priority();
      t_hold_request();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end

endmodule